// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each data beat of an SDRAM read or write burst. The command logic pulses a start strobe together with the first column. It also presents the mode-register burst-length code, the ordering bit and the single-write bit, and says whether the access is a write. From the cycle after the start, the generator shows one column per beat. The data path pulses an advance strobe to move on to the next beat.

Two orderings are supported. Sequential ordering wraps inside an aligned block of the burst length. Interleaved ordering XORs the low bits of the start column with the beat number. Lengths of 1, 2, 4 and 8 beats are supported, plus a full-page mode that walks the whole column space until it is stopped. The settings are captured when the burst starts, so a later mode change does not affect a burst already running. A terminate strobe, such as a precharge, ends the burst. A fresh start strobe restarts it from a new column.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high and in the cycle after it falls, valid_o, last_o and cfg_err_o are 0.
- R2: A start_i pulse sampled at a clock edge makes valid_o 1 from that edge on, and col_o then equals the supplied start column.
- R3: With ord_i = 0 and a finite length L, beat k shows the bits above log2(L) of the start column unchanged, and the low bits equal (start + k) mod L.
- R4: With ord_i = 1 and a finite length L, beat k shows the upper bits unchanged, and the low bits equal (start mod L) XOR k.
- R5: The length code len_code_i selects the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. An advance on the final beat makes valid_o 0 at the next edge.
- R6: Code 3'b111 with ord_i = 0 selects full page. The column is start + k mod 512, the burst never ends by advancing, and last_o stays 0.
- R7: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with ord_i = 1, give a one-beat burst with cfg_err_o = 1 while that burst is valid. Legal codes give cfg_err_o = 0.
- R8: With single_wr_i = 1, a write (is_wr_i = 1) lasts one beat whatever the code is. A read started with single_wr_i = 1 still uses the programmed length.
- R9: term_i without start_i makes valid_o 0 at the next edge.
- R10: advance_i while no burst is valid has no effect: valid_o stays 0.
- R11: start_i during a burst restarts it. The next beat is beat 0 of the new burst, using the new column and the new mode.
- R12: last_o is 1 exactly on the final beat of a finite burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst at start_col_i |
| start_col_i | input | 9 | First column of the burst |
| is_wr_i | input | 1 | Burst being started is a write |
| len_code_i | input | 3 | Burst-length code from the mode register |
| ord_i | input | 1 | 0 = sequential, 1 = interleaved |
| single_wr_i | input | 1 | Writes forced to one beat |
| advance_i | input | 1 | Step to the next beat |
| term_i | input | 1 | End the burst now |
| col_o | output | 9 | Column of the current beat |
| valid_o | output | 1 | A beat is being shown |
| last_o | output | 1 | Current beat is the final one |
| cfg_err_o | output | 1 | Current burst was started with an illegal mode |

## Verification
The hardest situation to reach is the full-page wrap: the column must cross from 511 back to 0 with last_o still low. The stimulus starts a full-page burst near the top of the column space and advances it for more than 512 beats before terminating it, so the wrap is crossed twice. The restart case is driven by asserting a new start in the same cycle as a mid-burst beat. The scoreboard then expects the new burst's first column straight after the truncated old beats.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int LEN_LOG2_W = 2;

    typedef enum logic {
        ORD_WRAP = 1'b0,
        ORD_XOR  = 1'b1
    } order_e;

    typedef enum logic [2:0] {
        LC_ONE  = 3'b000,
        LC_TWO  = 3'b001,
        LC_FOUR = 3'b010,
        LC_EIGHT = 3'b011,
        LC_PAGE = 3'b111
    } len_code_e;

    typedef struct packed {
        logic [LEN_LOG2_W-1:0] len_log2;
        logic                  full;
        order_e                order;
        logic                  err;
    } burst_cfg_t;

    function automatic logic [LEN_LOG2_W-1:0] code_to_log2(input logic [2:0] code);
        return code[LEN_LOG2_W-1:0];
    endfunction

endpackage

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode
    import bcg_pkg::*;
(
    input  logic [2:0] len_code_i,
    input  logic       ord_i,
    input  logic       is_wr_i,
    input  logic       single_wr_i,
    output burst_cfg_t cfg_o
);
    burst_cfg_t raw;

    always_comb begin
        raw          = '0;
        raw.order    = order_e'(ord_i);
        unique case (len_code_i)
            LC_ONE, LC_TWO, LC_FOUR, LC_EIGHT: raw.len_log2 = code_to_log2(len_code_i);
            LC_PAGE: begin
                if (ord_i == 1'b0) raw.full = 1'b1;
                else               raw.err  = 1'b1;
            end
            default: raw.err = 1'b1;
        endcase
        cfg_o = raw;
        if (is_wr_i && single_wr_i) begin
            cfg_o.len_log2 = '0;
            cfg_o.full     = 1'b0;
        end
    end
endmodule

// File: rtl/bcg_beat_counter.sv
module bcg_beat_counter
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  burst_cfg_t       cfg_i,
    input  logic             advance_i,
    input  logic             term_i,
    output logic             active_o,
    output logic [COL_W-1:0] cnt_o,
    output logic [COL_W-1:0] base_o,
    output burst_cfg_t       cfg_q_o,
    output logic             last_o
);
    logic [COL_W-1:0] beat_mask;

    assign beat_mask = (COL_W'(1) << cfg_q_o.len_log2) - COL_W'(1);
    assign last_o    = active_o && !cfg_q_o.full && (cnt_o == beat_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            cnt_o    <= '0;
            base_o   <= '0;
            cfg_q_o  <= '0;
        end else if (start_i) begin
            active_o <= 1'b1;
            cnt_o    <= '0;
            base_o   <= start_col_i;
            cfg_q_o  <= cfg_i;
        end else if (term_i) begin
            active_o <= 1'b0;
        end else if (advance_i && active_o) begin
            if (last_o) active_o <= 1'b0;
            else        cnt_o    <= cnt_o + COL_W'(1);
        end
    end

    // R3: each accepted advance moves exactly one beat
    a_r3_count_steps: assert property (@(posedge clk) disable iff (rst)
        active_o && advance_i && !last_o && !start_i && !term_i
        |=> active_o && cnt_o == $past(cnt_o) + COL_W'(1));

    // R2: a start clears the beat number
    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        start_i |=> active_o && cnt_o == '0);
endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  burst_cfg_t       cfg_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] low_mask;
    logic [COL_W-1:0] walked;

    always_comb begin
        if (cfg_i.full) low_mask = '1;
        else            low_mask = (COL_W'(1) << cfg_i.len_log2) - COL_W'(1);
        if (cfg_i.order == ORD_XOR) walked = base_i ^ cnt_i;
        else                        walked = base_i + cnt_i;
        col_o = (base_i & ~low_mask) | (walked & low_mask);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             is_wr_i,
    input  logic [2:0]       len_code_i,
    input  logic             ord_i,
    input  logic             single_wr_i,
    input  logic             advance_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             cfg_err_o
);
    burst_cfg_t       cfg_new;
    burst_cfg_t       cfg_q;
    logic             active;
    logic [COL_W-1:0] cnt;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] upper_mask;

    bcg_mode_decode u_decode (
        .len_code_i  (len_code_i),
        .ord_i       (ord_i),
        .is_wr_i     (is_wr_i),
        .single_wr_i (single_wr_i),
        .cfg_o       (cfg_new)
    );

    bcg_beat_counter #(.COL_W(COL_W)) u_counter (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .cfg_i       (cfg_new),
        .advance_i   (advance_i),
        .term_i      (term_i),
        .active_o    (active),
        .cnt_o       (cnt),
        .base_o      (base),
        .cfg_q_o     (cfg_q),
        .last_o      (last_o)
    );

    bcg_col_map #(.COL_W(COL_W)) u_map (
        .base_i (base),
        .cnt_i  (cnt),
        .cfg_i  (cfg_q),
        .col_o  (col_o)
    );

    assign valid_o    = active;
    assign cfg_err_o  = active && cfg_q.err;
    assign upper_mask = cfg_q.full ? '0 : ~((COL_W'(1) << cfg_q.len_log2) - COL_W'(1));

    // R2: first beat shows the supplied column
    a_r2_first_col: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o && col_o == $past(start_col_i));

    // R9: terminate ends the burst
    a_r9_term_ends: assert property (@(posedge clk) disable iff (rst)
        term_i && !start_i |=> !valid_o);

    // R10: advance alone cannot open a burst
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid_o && !start_i |=> !valid_o);

    // R5: advancing past the final beat closes the burst
    a_r5_end_after_last: assert property (@(posedge clk) disable iff (rst)
        last_o && advance_i && !start_i && !term_i |=> !valid_o);

    // R6: full page never flags a last beat
    a_r6_page_no_last: assert property (@(posedge clk) disable iff (rst)
        valid_o && cfg_q.full |-> !last_o);

    // R12: last beat only inside a burst
    a_r12_last_in_burst: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    // R3: block bits above the burst length stay put between beats
    a_r3_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        valid_o && advance_i && !last_o && !start_i && !term_i
        |=> (col_o & $past(upper_mask)) == ($past(col_o) & $past(upper_mask)));
endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 9;

    typedef struct {
        logic [COL_W-1:0] col;
        logic             last;
        logic             err;
        string            tag;
    } beat_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic             is_wr_i = 1'b0;
    logic [2:0]       len_code_i = 3'b000;
    logic             ord_i = 1'b0;
    logic             single_wr_i = 1'b0;
    logic             advance_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, cfg_err_o;

    int checks = 0;
    int errors = 0;
    beat_t expq[$];

    burst_col_gen #(.COL_W(COL_W)) u_burst_col_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .is_wr_i(is_wr_i), .len_code_i(len_code_i), .ord_i(ord_i),
        .single_wr_i(single_wr_i), .advance_i(advance_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .cfg_err_o(cfg_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // monitor: every valid beat pops one expected item
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && valid_o) begin
                checks++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected beat col=%0d expected none", col_o);
                end else begin
                    beat_t e;
                    e = expq.pop_front();
                    if (col_o !== e.col || last_o !== e.last || cfg_err_o !== e.err) begin
                        errors++;
                        $display("FAIL %s col=%0d last=%0b err=%0b expected col=%0d last=%0b err=%0b",
                                 e.tag, col_o, last_o, cfg_err_o, e.col, e.last, e.err);
                    end
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic check_idle(input string tag);
        checks++;
        if (valid_o !== 1'b0 || last_o !== 1'b0 || cfg_err_o !== 1'b0) begin
            errors++;
            $display("FAIL %s valid=%0b last=%0b err=%0b expected 0 0 0", tag, valid_o, last_o, cfg_err_o);
        end
    endtask

    // end_mode: 0 advance off the end, 1 terminate, 2 leave running for a restart
    task automatic burst(input int scol, input logic [2:0] code, input logic ord,
                         input logic wr, input logic sw, input int n_vis,
                         input int end_mode, input string tag);
        int len;
        bit full, err;
        err  = (code > 3'b011 && code != 3'b111) || (code == 3'b111 && ord);
        full = (code == 3'b111) && !ord;
        if (err) begin len = 1; full = 0; end
        else if (!full) len = 1 << code;
        else len = 0;
        if (wr && sw) begin len = 1; full = 0; end
        for (int k = 0; k < n_vis; k++) begin
            beat_t b;
            if (full) b.col = COL_W'((scol + k) % 512);
            else if (ord) b.col = COL_W'(scol - scol % len + ((scol % len) ^ k));
            else b.col = COL_W'(scol - scol % len + (scol % len + k) % len);
            b.last = !full && (k == len - 1);
            b.err  = err;
            b.tag  = tag;
            expq.push_back(b);
        end
        start_i = 1'b1; start_col_i = COL_W'(scol); len_code_i = code;
        ord_i = ord; is_wr_i = wr; single_wr_i = sw;
        advance_i = 1'b0; term_i = 1'b0;
        tick();
        start_i = 1'b0;
        // mode fields change after start: must not affect the running burst
        len_code_i = 3'b000; ord_i = ~ord;
        for (int k = 0; k < n_vis - 1; k++) begin
            advance_i = 1'b1;
            tick();
        end
        advance_i = 1'b0;
        if (end_mode == 0) begin advance_i = 1'b1; tick(); advance_i = 1'b0; end
        else if (end_mode == 1) begin term_i = 1'b1; tick(); term_i = 1'b0; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        check_idle("R1 in reset");
        rst = 1'b0;
        tick();
        check_idle("R1 after reset");

        burst(5, 3'b011, 1'b0, 1'b0, 1'b0, 8, 0, "R3 R5 R12 wrap len8");
        check_idle("R5 closed after last");
        burst(5, 3'b011, 1'b1, 1'b0, 1'b0, 8, 0, "R4 xor len8");
        burst(13, 3'b010, 1'b0, 1'b1, 1'b0, 4, 0, "R3 wrap len4");
        burst(7, 3'b001, 1'b1, 1'b0, 1'b0, 2, 0, "R4 xor len2");
        burst(300, 3'b000, 1'b0, 1'b0, 1'b0, 1, 0, "R5 len1");
        check_idle("R5 len1 closed");
        burst(500, 3'b111, 1'b0, 1'b0, 1'b0, 530, 1, "R6 full page wrap");
        check_idle("R9 page terminated");
        burst(9, 3'b100, 1'b0, 1'b0, 1'b0, 1, 0, "R7 reserved code");
        burst(9, 3'b110, 1'b1, 1'b0, 1'b0, 1, 0, "R7 reserved code 110");
        burst(33, 3'b111, 1'b1, 1'b0, 1'b0, 1, 0, "R7 page with xor");
        check_idle("R7 error burst closed");
        burst(20, 3'b011, 1'b0, 1'b1, 1'b1, 1, 0, "R8 single write");
        check_idle("R8 single write one beat");
        burst(20, 3'b011, 1'b0, 1'b0, 1'b1, 8, 0, "R8 read keeps length");
        burst(2, 3'b011, 1'b0, 1'b0, 1'b0, 3, 1, "R9 terminate");
        check_idle("R9 after terminate");
        burst(3, 3'b011, 1'b0, 1'b0, 1'b0, 3, 2, "R11 old burst");
        burst(42, 3'b010, 1'b1, 1'b0, 1'b0, 4, 0, "R11 restarted burst");
        for (int k = 0; k < 4; k++) begin
            advance_i = 1'b1;
            tick();
            check_idle("R10 advance while idle");
        end
        advance_i = 1'b0;
        tick();

        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL scoreboard left=%0d expected 0", expq.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule